// File: doc/BRIEF.md
# Clamp and Blanking Pulse Generator

This block derives the timing pulses that a video front end needs around each line retrace. From a horizontal sync input of unknown polarity, a flyback input and an overlay fast-blank input, it produces an input clamp pulse, an output clamp pulse, a normalised (positive-going) flyback signal and a combined video blank. All inputs are synchronous to the block clock. Static configuration inputs come from a register bank.

The input clamp pulse is either timed by a counter, started by a chosen edge of sync or flyback, or it is the sync input passed straight through. Its width is one of four values computed from the clock frequency parameter. The output clamp pulse either follows the input clamp pulse or is timed from the start of the normalised flyback. Sync polarity is learned by comparing the time spent high and low over a fixed window.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset with all inputs low, icp, ocp, blki and video_blank are all 0, and sync is treated as positive-going.
- R2: In timed modes a pulse lasts N clock cycles, where N = round(CLK_HZ*(cfg_width+1)/3e6). At 50 MHz this gives 17, 33, 50 and 67 cycles for cfg_width 0 to 3.
- R3: With cfg_src=00, the pulse is started by normalised sync. cfg_edge=0 selects the falling (trailing) edge and cfg_edge=1 the rising (leading) edge. icp rises on the first clock edge that samples the triggering level.
- R4: Each HS_WINDOW-cycle window counts the cycles with hs_in high. If that count exceeds half the window, sync is treated as active-low (inverted) from the next window on.
- R5: When cfg_src bit 1 is 1, icp equals hs_in delayed by one clock, whatever the values of cfg_width, cfg_edge or the learned polarity.
- R6: With cfg_src=01, the pulse is started by blki. cfg_edge=0 selects the rising edge of blki and cfg_edge=1 its falling edge. On the pin this means rising, falling, falling, rising for {cfg_edge,cfg_blk_inv} = 00, 01, 10, 11.
- R7: blki equals blk_in XOR cfg_blk_inv.
- R8: When cfg_ocp_copy=1, ocp is identical to icp. When it is 0, ocp is an R2-width pulse started by each rising edge of blki.
- R9: A qualifying edge that arrives while a pulse is active restarts the full width count.
- R10: video_blank is high when blki, fblk_in, or both cfg_sw_blank and cfg_blank_unlock are high. cfg_sw_blank alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Horizontal sync, either polarity |
| blk_in | input | 1 | Flyback / blanking input |
| fblk_in | input | 1 | Overlay fast-blank input |
| cfg_src | input | 2 | Clamp source: 00 sync edge, 01 flyback edge, 1x sync pass-through |
| cfg_width | input | 2 | Timed pulse width step |
| cfg_edge | input | 1 | Trigger edge select |
| cfg_blk_inv | input | 1 | Invert flyback input |
| cfg_ocp_copy | input | 1 | Output clamp copies input clamp |
| cfg_sw_blank | input | 1 | Software blank request |
| cfg_blank_unlock | input | 1 | Enable for software blank |
| icp | output | 1 | Input clamp pulse |
| ocp | output | 1 | Output clamp pulse |
| blki | output | 1 | Normalised flyback |
| video_blank | output | 1 | Combined video blank |

## Verification
The hardest state to reach is the learned active-low sync polarity. It only exists after a full measurement window of negative sync has been seen, and the polarity switch itself produces a spurious edge. The stimulus drives a dozen negative-going lines with result comparison suspended, then re-enables the scoreboard and expects trailing-edge pulses at the end of the low phase. Retriggering is reached by a flyback glitch whose second rising edge lands inside a running pulse. The scoreboard expects one stretched pulse, not two.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef struct packed {
        logic [1:0] src;
        logic [1:0] width;
        logic       edge_sel;
        logic       blk_inv;
        logic       ocp_copy;
        logic       sw_blank;
        logic       blank_unlock;
    } cpg_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    localparam logic [1:0] SRC_HS_EDGE  = 2'b00;
    localparam logic [1:0] SRC_BLK_EDGE = 2'b01;

    // Width step n lasts (n+1)/3 microseconds, rounded to whole clocks.
    function automatic int width_cycles(input int clk_hz, input int step);
        longint num;
        num = longint'(clk_hz) * longint'(step + 1) + 64'sd1500000;
        return int'(num / 64'sd3000000);
    endfunction

    function automatic edge_t detect(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

endpackage

// File: rtl/cpg_hs_polarity.sv
module cpg_hs_polarity #(
    parameter int HS_WINDOW = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_in,
    output logic hs_norm
);
    localparam int CW = $clog2(HS_WINDOW + 1);

    logic [CW-1:0] win_cnt;
    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] hi_total;
    logic [CW:0]   hi_dbl;
    logic          pol_neg;
    logic          win_end;

    assign win_end  = (win_cnt == CW'(HS_WINDOW - 1));
    assign hi_total = hi_cnt + CW'(hs_in);
    assign hi_dbl   = {hi_total, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            hi_cnt  <= '0;
            pol_neg <= 1'b0;
        end else if (win_end) begin
            win_cnt <= '0;
            hi_cnt  <= '0;
            pol_neg <= (hi_dbl > (CW+1)'(HS_WINDOW));
        end else begin
            win_cnt <= win_cnt + CW'(1);
            hi_cnt  <= hi_total;
        end
    end

    assign hs_norm = hs_in ^ pol_neg;

    // R4: the polarity decision only moves at a window boundary
    assert_pol_update_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(pol_neg)) |-> $past(win_end));

endmodule

// File: rtl/cpg_trigger_sel.sv
module cpg_trigger_sel
    import cpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hs_norm,
    input  logic       blki,
    input  logic [1:0] src,
    input  logic       edge_sel,
    output logic       icp_trig,
    output logic       ocp_trig
);
    logic  hs_q;
    logic  blk_q;
    edge_t hs_e;
    edge_t blk_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q  <= 1'b0;
            blk_q <= 1'b0;
        end else begin
            hs_q  <= hs_norm;
            blk_q <= blki;
        end
    end

    assign hs_e  = detect(hs_norm, hs_q);
    assign blk_e = detect(blki, blk_q);

    always_comb begin
        case (src)
            SRC_HS_EDGE:  icp_trig = edge_sel ? hs_e.rise  : hs_e.fall;
            SRC_BLK_EDGE: icp_trig = edge_sel ? blk_e.fall : blk_e.rise;
            default:      icp_trig = 1'b0;
        endcase
    end

    assign ocp_trig = blk_e.rise;

    // R3: a sync-sourced trigger coincides with a change of normalised sync
    assert_hs_trig_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && src == SRC_HS_EDGE && icp_trig) |-> (hs_norm != $past(hs_norm)));

    // R6: a flyback-sourced trigger coincides with a change of blki
    assert_blk_trig_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && src == SRC_BLK_EDGE && icp_trig) |-> (blki != $past(blki)));

endmodule

// File: rtl/cpg_pulse_timer.sv
module cpg_pulse_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [CW-1:0] len,
    output logic          pulse
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
            cnt   <= '0;
        end else if (trig) begin
            pulse <= 1'b1;
            cnt   <= len - CW'(1);
        end else if (cnt != '0) begin
            cnt   <= cnt - CW'(1);
        end else begin
            pulse <= 1'b0;
        end
    end

    // R9: every trigger, even mid-pulse, leaves the pulse active next cycle
    assert_trig_holds_R9: assert property (@(posedge clk) disable iff (rst)
        trig |=> pulse);

    // R2: the pulse never starts without a trigger
    assert_start_needs_trig_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(pulse)) |-> $past(trig));

    // R2: an exhausted count with no new trigger ends the pulse
    assert_pulse_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse && cnt == '0 && !trig) |=> !pulse);

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import cpg_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int HS_WINDOW = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hs_in,
    input  logic       blk_in,
    input  logic       fblk_in,
    input  logic [1:0] cfg_src,
    input  logic [1:0] cfg_width,
    input  logic       cfg_edge,
    input  logic       cfg_blk_inv,
    input  logic       cfg_ocp_copy,
    input  logic       cfg_sw_blank,
    input  logic       cfg_blank_unlock,
    output logic       icp,
    output logic       ocp,
    output logic       blki,
    output logic       video_blank
);
    localparam int MAX_W = width_cycles(CLK_HZ, 3);
    localparam int CW    = $clog2(MAX_W + 1);
    localparam int STEPS = 4;

    cpg_cfg_t      cfg;
    logic [CW-1:0] width_lut [STEPS];
    logic [CW-1:0] len;
    logic          hs_norm;
    logic          icp_trig;
    logic          ocp_trig;
    logic          icp_timed;
    logic          ocp_timed;
    logic          hs_pass_q;

    assign cfg = '{src: cfg_src, width: cfg_width, edge_sel: cfg_edge,
                   blk_inv: cfg_blk_inv, ocp_copy: cfg_ocp_copy,
                   sw_blank: cfg_sw_blank, blank_unlock: cfg_blank_unlock};

    for (genvar i = 0; i < STEPS; i++) begin : g_width
        assign width_lut[i] = CW'(width_cycles(CLK_HZ, i));
    end

    assign len  = width_lut[cfg.width];
    assign blki = blk_in ^ cfg.blk_inv;

    cpg_hs_polarity #(.HS_WINDOW(HS_WINDOW)) u_pol (
        .clk(clk), .rst(rst), .hs_in(hs_in), .hs_norm(hs_norm)
    );

    cpg_trigger_sel u_sel (
        .clk(clk), .rst(rst), .hs_norm(hs_norm), .blki(blki),
        .src(cfg.src), .edge_sel(cfg.edge_sel),
        .icp_trig(icp_trig), .ocp_trig(ocp_trig)
    );

    cpg_pulse_timer #(.CW(CW)) u_icp_tmr (
        .clk(clk), .rst(rst), .trig(icp_trig), .len(len), .pulse(icp_timed)
    );

    cpg_pulse_timer #(.CW(CW)) u_ocp_tmr (
        .clk(clk), .rst(rst), .trig(ocp_trig), .len(len), .pulse(ocp_timed)
    );

    always_ff @(posedge clk) begin
        if (rst) hs_pass_q <= 1'b0;
        else     hs_pass_q <= hs_in;
    end

    assign icp = cfg.src[1] ? hs_pass_q : icp_timed;
    assign ocp = cfg.ocp_copy ? icp : ocp_timed;
    assign video_blank = blki | fblk_in | (cfg.sw_blank & cfg.blank_unlock);

    // R5: pass-through follows the sync pin one clock later
    assert_pass_follow_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cfg_src[1] && $past(cfg_src[1])) |-> (icp == $past(hs_in)));

    // R10: any hardware blank source forces the video blank
    assert_hw_blank_R10: assert property (@(posedge clk) disable iff (rst)
        (blki || fblk_in) |-> video_blank);

    // R10: software blank without its unlock is ignored
    assert_sw_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (!blki && !fblk_in && !cfg_blank_unlock) |-> !video_blank);

endmodule

// File: tb/clamp_pulse_gen_bench.sv
module clamp_pulse_gen_bench;

    logic clk = 1'b0;
    logic rst;
    logic hs_in, blk_in, fblk_in;
    logic [1:0] cfg_src, cfg_width;
    logic cfg_edge, cfg_blk_inv, cfg_ocp_copy, cfg_sw_blank, cfg_blank_unlock;
    logic icp, ocp, blki, video_blank;

    always #10 clk = ~clk;

    clamp_pulse_gen u_clamp_pulse_gen (
        .clk(clk), .rst(rst), .hs_in(hs_in), .blk_in(blk_in), .fblk_in(fblk_in),
        .cfg_src(cfg_src), .cfg_width(cfg_width), .cfg_edge(cfg_edge),
        .cfg_blk_inv(cfg_blk_inv), .cfg_ocp_copy(cfg_ocp_copy),
        .cfg_sw_blank(cfg_sw_blank), .cfg_blank_unlock(cfg_blank_unlock),
        .icp(icp), .ocp(ocp), .blki(blki), .video_blank(video_blank)
    );

    typedef struct {
        int    start;
        int    len;
        string req;
    } exp_t;

    exp_t icp_q[$];
    exp_t ocp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int wcyc(input int step);
        return (100 * (step + 1) + 3) / 6;   // 50 MHz, (step+1)/3 us rounded
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare(input string name, input int st, input int ln, ref exp_t q[$]);
        exp_t e;
        if (q.size() == 0) begin
            chk(0, "R2", {name, " unexpected pulse start"}, st, -1);
        end else begin
            e = q.pop_front();
            chk(st == e.start, e.req, {name, " start cycle"}, st, e.start);
            chk(ln == e.len,   e.req, {name, " width"},       ln, e.len);
        end
    endtask

    // scoreboard monitors
    bit icp_on = 0; int icp_st = 0; int icp_len = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (icp) begin
                if (!icp_on) begin icp_on = 1; icp_st = cyc; icp_len = 0; end
                icp_len++;
            end else if (icp_on) begin
                icp_on = 0;
                if (mon_en) compare("icp", icp_st, icp_len, icp_q);
            end
        end
    end

    bit ocp_on = 0; int ocp_st = 0; int ocp_len = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ocp) begin
                if (!ocp_on) begin ocp_on = 1; ocp_st = cyc; ocp_len = 0; end
                ocp_len++;
            end else if (ocp_on) begin
                ocp_on = 0;
                if (mon_en) compare("ocp", ocp_st, ocp_len, ocp_q);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        mon_en = 0;
        idle(160);
        mon_en = 1;
    endtask

    // one sync line; pushes expected icp (and ocp copy) before driving
    task automatic hs_line(input bit neg, input int act, input int idl,
                           input bit exp_p, input bit lead, input int w, input string req);
        int c;
        exp_t e;
        c = cyc;
        if (exp_p) begin
            e.start = lead ? c + 1 : c + act + 1;
            e.len = w;
            e.req = req;
            icp_q.push_back(e);
            ocp_q.push_back(e);
        end
        hs_in = neg ? 1'b0 : 1'b1;
        idle(act);
        hs_in = neg ? 1'b1 : 1'b0;
        idle(idl);
    endtask

    // one flyback pulse; edge refers to blki, ocp is timed from blki rising
    task automatic blk_line(input int act, input int idl, input int w, input string req);
        int c;
        exp_t e;
        c = cyc;
        e.start = cfg_edge ? c + act + 1 : c + 1;
        e.len = w;
        e.req = req;
        icp_q.push_back(e);
        e.start = c + 1;
        e.req = "R8";
        ocp_q.push_back(e);
        blk_in = cfg_blk_inv ? 1'b0 : 1'b1;
        idle(act);
        blk_in = cfg_blk_inv ? 1'b1 : 1'b0;
        idle(idl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_t e;
        int c;
        rst = 1; hs_in = 0; blk_in = 0; fblk_in = 0;
        cfg_src = 2'b00; cfg_width = 2'd1; cfg_edge = 0; cfg_blk_inv = 0;
        cfg_ocp_copy = 1; cfg_sw_blank = 0; cfg_blank_unlock = 0;
        idle(5);
        rst = 0;
        idle(2);
        // R1: reset state
        chk(icp == 0, "R1", "icp after reset", icp, 0);
        chk(ocp == 0, "R1", "ocp after reset", ocp, 0);
        chk(blki == 0, "R1", "blki after reset", blki, 0);
        chk(video_blank == 0, "R1", "video_blank after reset", video_blank, 0);
        settle();

        // R2 and R3: positive sync, trailing edge, every width step
        for (int s = 0; s < 4; s++) begin
            cfg_width = 2'(s);
            idle(2);
            hs_line(0, 20, 180, 1, 0, wcyc(s), "R2");
        end
        // R3: leading edge
        cfg_edge = 1; cfg_width = 2'd2;
        settle();
        hs_line(0, 20, 180, 1, 1, wcyc(2), "R3");
        hs_line(0, 30, 170, 1, 1, wcyc(2), "R3");

        // R4: learn active-low sync, then trailing edge = end of low phase
        mon_en = 0;
        cfg_edge = 0; cfg_width = 2'd1;
        hs_in = 1;
        for (int k = 0; k < 12; k++) hs_line(1, 20, 180, 0, 0, 0, "R4");
        mon_en = 1;
        for (int k = 0; k < 3; k++) hs_line(1, 20, 180, 1, 0, wcyc(1), "R4");

        // R5: pass-through, width and edge settings ignored
        mon_en = 0;
        hs_in = 0; cfg_src = 2'b10; cfg_width = 2'd3; cfg_edge = 1;
        settle();
        hs_line(0, 7, 60, 1, 1, 7, "R5");
        hs_line(0, 90, 60, 1, 1, 90, "R5");

        // R6 and R8: flyback trigger, all edge/inversion combinations
        cfg_src = 2'b01; cfg_ocp_copy = 0;
        for (int m = 0; m < 4; m++) begin
            mon_en = 0;
            cfg_edge = m[1];
            cfg_blk_inv = m[0];
            blk_in = cfg_blk_inv;
            cfg_width = 2'(m);
            settle();
            blk_line(100, 120, wcyc(m), "R6");
            blk_line(80, 140, wcyc(m), "R6");
        end

        // R9: second rising edge inside a running pulse restarts the count
        mon_en = 0;
        cfg_edge = 0; cfg_blk_inv = 0; blk_in = 0; cfg_width = 2'd1;
        settle();
        c = cyc;
        e.start = c + 1; e.len = 10 + wcyc(1); e.req = "R9";
        icp_q.push_back(e);
        ocp_q.push_back(e);
        blk_in = 1; idle(5);
        blk_in = 0; idle(5);
        blk_in = 1; idle(60);
        blk_in = 0; idle(120);

        chk(icp_q.size() == 0, "R2", "icp expectations left", icp_q.size(), 0);
        chk(ocp_q.size() == 0, "R8", "ocp expectations left", ocp_q.size(), 0);

        // R7 and R10: static blanking paths
        mon_en = 0;
        blk_in = 1; cfg_blk_inv = 0; idle(1);
        chk(blki == 1, "R7", "blki pin high no inv", blki, 1);
        chk(video_blank == 1, "R10", "blank from blki", video_blank, 1);
        cfg_blk_inv = 1; idle(1);
        chk(blki == 0, "R7", "blki pin high inverted", blki, 0);
        chk(video_blank == 0, "R10", "no blank source", video_blank, 0);
        fblk_in = 1; idle(1);
        chk(video_blank == 1, "R10", "blank from fast blank", video_blank, 1);
        fblk_in = 0; cfg_sw_blank = 1; cfg_blank_unlock = 0; idle(1);
        chk(video_blank == 0, "R10", "sw blank without unlock", video_blank, 0);
        cfg_blank_unlock = 1; idle(1);
        chk(video_blank == 1, "R10", "sw blank with unlock", video_blank, 1);
        cfg_sw_blank = 0; idle(1);
        chk(video_blank == 0, "R10", "unlock alone", video_blank, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule